// File: doc/BRIEF.md
# Line Home Directory with DMA Recall

This block is the home agent for a set of cache lines under a single-owner coherence scheme. It sits between the caches, a memory controller and a DMA engine. Caches ask it for a line and it fetches the line from memory and grants ownership to that requestor. When the owner later gives the line up, the block returns it to the invalid state. A clean give-up is acknowledged at once. A dirty give-up is written to memory first and acknowledged after memory confirms.

The DMA engine reads and writes lines through the same block. When the DMA target is not owned, the block goes straight to memory. When a cache owns it, the block first recalls the line by invalidating the owner. For a DMA read, the recalled data is handed whole to the DMA engine and also written back. For a DMA write, the DMA bytes are laid over the recalled line at their address offset, and the merged line is written back in full.

A small table matched by line tag holds the tracked lines, each with its state and its one-hot owner. One transient buffer holds the payload of a DMA write while its recall is in flight. Every channel uses a valid/ready handshake. A request that cannot proceed stays at the head of its channel with ready low, and the other channels keep moving.

Top module: `dir_dma_ctrl`

## Requirements
- R1: A fetch for an untracked line issues a memory read for that line. When the memory data returns, it is sent to the requestor with cout_kind 0 (data). From then on the requestor is the line's sole owner.
- R2: A clean response (crsp_dirty 0) for an owned line sends cout_kind 1 (ack) to the sender and frees the line.
- R3: A dirty response (crsp_dirty 1) for an owned line issues a memory write of the whole line, with every bit of mreq_be set. The memory ack then sends cout_kind 1 to the owner and frees the line.
- R4: A DMA read (dreq_write 0) of an owned line sends cout_kind 2 (invalidate) to the owner. The owner's dirty data then goes unchanged to the DMA engine (dout_ack 0) and is written to memory. The memory ack then sends cout_kind 1 to the owner and frees the line.
- R5: A DMA write of an owned line sends cout_kind 2 to the owner. The owner's data is then written to memory with every bit of mreq_be set. In that write, bytes offset to offset+len-1 come from the DMA data and the rest come from the owner. The offset is the low six bits of dreq_addr; byte b sits in data bits 8b+7..8b. The memory ack then sends cout_kind 1 to the owner and dout_ack 1 to the DMA engine.
- R6: A DMA read of an untracked line issues a memory read, and the returned data goes to the DMA engine. A DMA write of an untracked line issues a memory write of dreq_data, with mreq_be bit b set only for bytes offset to offset+len-1. After the memory ack, the block sends dout_ack 1.
- R7: A fetch for a tracked line is held with creq_ready low and is not dropped. It is accepted once the line is free again.
- R8: A DMA request for a line in a transient state is held with dreq_ready low. It is accepted once the line settles in the owned state.
- R9: A held request does not block the other input channels.
- R10: A free line records no owner, and an owned line records exactly one owner.
- R11: When every table entry is in use, a request that needs a new entry is held until an entry is freed.
- R12: At most one input is accepted per cycle, in this priority: memory response, cache response, DMA request, fetch. Each output keeps its payload stable while valid is high and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| creq_valid | input | 1 | Fetch request valid |
| creq_ready | output | 1 | Fetch request accepted |
| creq_line | input | LAW | Line address of the fetch |
| creq_src | input | IDW | Requesting cache ID |
| crsp_valid | input | 1 | Cache response valid |
| crsp_ready | output | 1 | Cache response accepted |
| crsp_dirty | input | 1 | 1 = dirty data, 0 = clean give-up |
| crsp_line | input | LAW | Line address of the response |
| crsp_src | input | IDW | Responding cache ID |
| crsp_data | input | 8*LINE_BYTES | Dirty line data |
| dreq_valid | input | 1 | DMA request valid |
| dreq_ready | output | 1 | DMA request accepted |
| dreq_write | input | 1 | 1 = write, 0 = read |
| dreq_addr | input | LAW+log2(LINE_BYTES) | DMA byte address |
| dreq_len | input | log2(LINE_BYTES)+1 | DMA byte count |
| dreq_data | input | 8*LINE_BYTES | DMA write bytes at their line positions |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request taken |
| mreq_write | output | 1 | 1 = write, 0 = read |
| mreq_line | output | LAW | Memory line address |
| mreq_data | output | 8*LINE_BYTES | Write data |
| mreq_be | output | LINE_BYTES | Byte enables for writes |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_ready | output | 1 | Memory response accepted |
| mrsp_ack | input | 1 | 1 = write ack, 0 = read data |
| mrsp_line | input | LAW | Line address of the response |
| mrsp_data | input | 8*LINE_BYTES | Read data |
| cout_valid | output | 1 | Cache response out valid |
| cout_ready | input | 1 | Cache response out taken |
| cout_kind | output | 2 | 0 data, 1 ack, 2 invalidate |
| cout_dst | output | IDW | Destination cache ID |
| cout_line | output | LAW | Line address |
| cout_data | output | 8*LINE_BYTES | Line data for kind 0 |
| dout_valid | output | 1 | DMA response valid |
| dout_ready | input | 1 | DMA response taken |
| dout_ack | output | 1 | 1 = write ack, 0 = read data |
| dout_line | output | LAW | Line address |
| dout_data | output | 8*LINE_BYTES | Read data |

## Verification
The bench builds the block with 64-byte lines, a 4-entry table, 8-bit line addresses and 2-bit cache IDs. With only four entries, the full-table stall is reached after four fetches. The 64-byte line puts every merge offset and length, from a single byte up to a whole line, within reach of the random DMA writes. Random flows mix all six transaction paths over random lines, owners, data, offsets and lengths. Directed cases then hold requests against busy lines, race two inputs in one cycle and back-pressure the memory channel.

// File: rtl/dir_dma_ctrl.sv
module dir_dma_ctrl #(
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES = 4,
  parameter int LAW = 8,
  parameter int IDW = 2,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int LB = LINE_BYTES * 8,
  localparam int NREQ = 1 << IDW,
  localparam int EW = $clog2(ENTRIES),
  localparam int LENW = OFFW + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic creq_valid,
  output logic creq_ready,
  input  logic [LAW-1:0] creq_line,
  input  logic [IDW-1:0] creq_src,
  input  logic crsp_valid,
  output logic crsp_ready,
  input  logic crsp_dirty,
  input  logic [LAW-1:0] crsp_line,
  input  logic [IDW-1:0] crsp_src,
  input  logic [LB-1:0] crsp_data,
  input  logic dreq_valid,
  output logic dreq_ready,
  input  logic dreq_write,
  input  logic [LAW+OFFW-1:0] dreq_addr,
  input  logic [LENW-1:0] dreq_len,
  input  logic [LB-1:0] dreq_data,
  output logic mreq_valid,
  input  logic mreq_ready,
  output logic mreq_write,
  output logic [LAW-1:0] mreq_line,
  output logic [LB-1:0] mreq_data,
  output logic [LINE_BYTES-1:0] mreq_be,
  input  logic mrsp_valid,
  output logic mrsp_ready,
  input  logic mrsp_ack,
  input  logic [LAW-1:0] mrsp_line,
  input  logic [LB-1:0] mrsp_data,
  output logic cout_valid,
  input  logic cout_ready,
  output logic [1:0] cout_kind,
  output logic [IDW-1:0] cout_dst,
  output logic [LAW-1:0] cout_line,
  output logic [LB-1:0] cout_data,
  output logic dout_valid,
  input  logic dout_ready,
  output logic dout_ack,
  output logic [LAW-1:0] dout_line,
  output logic [LB-1:0] dout_data
);
  localparam logic [3:0] S_I = 4'd0, S_IM = 4'd1, S_M = 4'd2, S_MI = 4'd3, S_ID = 4'd4,
    S_IDW = 4'd5, S_RD = 4'd6, S_RDI = 4'd7, S_WR = 4'd8, S_WRI = 4'd9;
  localparam logic [1:0] K_DATA = 2'd0, K_ACK = 2'd1, K_INV = 2'd2;

  logic [ENTRIES-1:0][3:0] e_st;
  logic [ENTRIES-1:0][LAW-1:0] e_tag;
  logic [ENTRIES-1:0][NREQ-1:0] e_own;

  logic tb_v;
  logic [OFFW-1:0] tb_off;
  logic [LENW-1:0] tb_len;
  logic [LB-1:0] tb_data;

  logic c_hit, r_hit, d_hit, m_hit, free_ok;
  logic [EW-1:0] c_idx, r_idx, d_idx, m_idx, free_idx;
  logic [3:0] r_st, d_st, m_st;
  logic m_go, r_go, d_go, q_go;

  wire [LAW-1:0] d_line = dreq_addr[LAW+OFFW-1:OFFW];
  wire [OFFW-1:0] d_off = dreq_addr[OFFW-1:0];

  function automatic logic [LINE_BYTES-1:0] span(input logic [OFFW-1:0] off, input logic [LENW-1:0] len);
    logic [LINE_BYTES-1:0] m;
    for (int b = 0; b < LINE_BYTES; b++)
      m[b] = (b >= int'(off)) && (b < int'(off) + int'(len));
    return m;
  endfunction

  function automatic logic [LB-1:0] overlay(input logic [LB-1:0] base, input logic [LB-1:0] top,
                                            input logic [LINE_BYTES-1:0] m);
    logic [LB-1:0] o;
    for (int b = 0; b < LINE_BYTES; b++)
      o[b*8 +: 8] = m[b] ? top[b*8 +: 8] : base[b*8 +: 8];
    return o;
  endfunction

  function automatic logic [IDW-1:0] enc(input logic [NREQ-1:0] oh);
    logic [IDW-1:0] id;
    id = '0;
    for (int i = 0; i < NREQ; i++)
      if (oh[i]) id = IDW'(i);
    return id;
  endfunction

  always_comb begin
    {c_hit, r_hit, d_hit, m_hit, free_ok} = '0;
    {c_idx, r_idx, d_idx, m_idx, free_idx} = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (e_st[i] == S_I) begin free_ok = 1'b1; free_idx = EW'(i); end
      if (e_st[i] != S_I && e_tag[i] == creq_line) begin c_hit = 1'b1; c_idx = EW'(i); end
      if (e_st[i] != S_I && e_tag[i] == crsp_line) begin r_hit = 1'b1; r_idx = EW'(i); end
      if (e_st[i] != S_I && e_tag[i] == d_line) begin d_hit = 1'b1; d_idx = EW'(i); end
      if (e_st[i] != S_I && e_tag[i] == mrsp_line) begin m_hit = 1'b1; m_idx = EW'(i); end
    end
  end

  assign r_st = r_hit ? e_st[r_idx] : S_I;
  assign d_st = d_hit ? e_st[d_idx] : S_I;
  assign m_st = m_hit ? e_st[m_idx] : S_I;

  assign m_go = mrsp_valid && m_hit && (
      (!mrsp_ack && m_st == S_IM && !cout_valid) ||
      (!mrsp_ack && m_st == S_ID && !dout_valid) ||
      (mrsp_ack && (m_st == S_MI || m_st == S_RDI) && !cout_valid) ||
      (mrsp_ack && m_st == S_IDW && !dout_valid) ||
      (mrsp_ack && m_st == S_WRI && !cout_valid && !dout_valid));

  assign r_go = crsp_valid && r_hit && !m_go && (
      (crsp_dirty && (r_st == S_M || r_st == S_WR) && !mreq_valid) ||
      (crsp_dirty && r_st == S_RD && !mreq_valid && !dout_valid) ||
      (!crsp_dirty && r_st == S_M && !cout_valid));

  assign d_go = dreq_valid && !m_go && !r_go && (
      (!d_hit && free_ok && !mreq_valid) ||
      (d_st == S_M && !cout_valid && (!dreq_write || !tb_v)));

  assign q_go = creq_valid && !c_hit && free_ok && !mreq_valid && !m_go && !r_go && !d_go;

  assign mrsp_ready = m_go;
  assign crsp_ready = r_go;
  assign dreq_ready = d_go;
  assign creq_ready = q_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_st <= '0; e_tag <= '0; e_own <= '0;
      tb_v <= 1'b0; tb_off <= '0; tb_len <= '0; tb_data <= '0;
      mreq_valid <= 1'b0; mreq_write <= 1'b0; mreq_line <= '0; mreq_data <= '0; mreq_be <= '0;
      cout_valid <= 1'b0; cout_kind <= K_DATA; cout_dst <= '0; cout_line <= '0; cout_data <= '0;
      dout_valid <= 1'b0; dout_ack <= 1'b0; dout_line <= '0; dout_data <= '0;
    end else begin
      if (mreq_valid && mreq_ready) mreq_valid <= 1'b0;
      if (cout_valid && cout_ready) cout_valid <= 1'b0;
      if (dout_valid && dout_ready) dout_valid <= 1'b0;

      if (m_go) begin
        case (m_st)
          S_IM: begin
            e_st[m_idx] <= S_M;
            cout_valid <= 1'b1; cout_kind <= K_DATA; cout_dst <= enc(e_own[m_idx]);
            cout_line <= mrsp_line; cout_data <= mrsp_data;
          end
          S_ID, S_IDW: begin
            e_st[m_idx] <= S_I;
            dout_valid <= 1'b1; dout_ack <= mrsp_ack; dout_line <= mrsp_line; dout_data <= mrsp_data;
          end
          default: begin
            e_st[m_idx] <= S_I;
            e_own[m_idx] <= '0;
            cout_valid <= 1'b1; cout_kind <= K_ACK; cout_dst <= enc(e_own[m_idx]);
            cout_line <= mrsp_line; cout_data <= '0;
            if (m_st == S_WRI) begin
              tb_v <= 1'b0;
              dout_valid <= 1'b1; dout_ack <= 1'b1; dout_line <= mrsp_line; dout_data <= '0;
            end
          end
        endcase
      end else if (r_go) begin
        if (!crsp_dirty) begin
          e_st[r_idx] <= S_I;
          e_own[r_idx] <= '0;
          cout_valid <= 1'b1; cout_kind <= K_ACK; cout_dst <= crsp_src;
          cout_line <= crsp_line; cout_data <= '0;
        end else begin
          mreq_valid <= 1'b1; mreq_write <= 1'b1; mreq_line <= crsp_line; mreq_be <= '1;
          mreq_data <= (r_st == S_WR) ? overlay(crsp_data, tb_data, span(tb_off, tb_len)) : crsp_data;
          e_st[r_idx] <= (r_st == S_M) ? S_MI : (r_st == S_RD) ? S_RDI : S_WRI;
          if (r_st == S_RD) begin
            dout_valid <= 1'b1; dout_ack <= 1'b0; dout_line <= crsp_line; dout_data <= crsp_data;
          end
        end
      end else if (d_go) begin
        if (!d_hit) begin
          e_st[free_idx] <= dreq_write ? S_IDW : S_ID;
          e_tag[free_idx] <= d_line;
          mreq_valid <= 1'b1; mreq_write <= dreq_write; mreq_line <= d_line;
          mreq_data <= dreq_data;
          mreq_be <= dreq_write ? span(d_off, dreq_len) : '1;
        end else begin
          e_st[d_idx] <= dreq_write ? S_WR : S_RD;
          cout_valid <= 1'b1; cout_kind <= K_INV; cout_dst <= enc(e_own[d_idx]);
          cout_line <= d_line; cout_data <= '0;
          if (dreq_write) begin
            tb_v <= 1'b1; tb_off <= d_off; tb_len <= dreq_len; tb_data <= dreq_data;
          end
        end
      end else if (q_go) begin
        e_st[free_idx] <= S_IM;
        e_tag[free_idx] <= creq_line;
        e_own[free_idx] <= NREQ'(1) << creq_src;
        mreq_valid <= 1'b1; mreq_write <= 1'b0; mreq_line <= creq_line;
        mreq_data <= '0; mreq_be <= '1;
      end
    end
  end
endmodule

module dir_dma_ctrl_chk #(
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES = 4,
  parameter int LAW = 8,
  parameter int IDW = 2,
  localparam int LB = LINE_BYTES * 8,
  localparam int NREQ = 1 << IDW
) (
  input logic clk,
  input logic rst_n,
  input logic [ENTRIES-1:0][3:0] e_st,
  input logic [ENTRIES-1:0][NREQ-1:0] e_own,
  input logic creq_valid, creq_ready, crsp_valid, crsp_ready,
  input logic dreq_valid, dreq_ready, mrsp_valid, mrsp_ready,
  input logic mreq_valid, mreq_ready, mreq_write,
  input logic [LAW-1:0] mreq_line,
  input logic [LB-1:0] mreq_data,
  input logic cout_valid, cout_ready,
  input logic [1:0] cout_kind,
  input logic [IDW-1:0] cout_dst,
  input logic [LAW-1:0] cout_line
);
  logic [ENTRIES-1:0] in_wr;
  always_comb
    for (int i = 0; i < ENTRIES; i++) in_wr[i] = (e_st[i] == 4'd8) || (e_st[i] == 4'd9);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    // R10
    owner_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      e_st[i] == 4'd0 |-> e_own[i] == '0);
    // R10
    owner_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      e_st[i] == 4'd2 |-> $countones(e_own[i]) == 1);
  end

  // R5
  wrbuf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_wr) <= 1);

  // R12
  one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({creq_valid && creq_ready, crsp_valid && crsp_ready,
                dreq_valid && dreq_ready, mrsp_valid && mrsp_ready}) <= 1);

  // R12
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_line) && $stable(mreq_data) && $stable(mreq_write));

  // R12
  cout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cout_valid && !cout_ready |=> cout_valid && $stable(cout_kind) && $stable(cout_dst) && $stable(cout_line));

  // R1
  fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid && creq_ready |=> mreq_valid && !mreq_write);
endmodule

bind dir_dma_ctrl dir_dma_ctrl_chk #(.LINE_BYTES(LINE_BYTES), .ENTRIES(ENTRIES), .LAW(LAW), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .e_st(e_st), .e_own(e_own),
  .creq_valid(creq_valid), .creq_ready(creq_ready), .crsp_valid(crsp_valid), .crsp_ready(crsp_ready),
  .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
  .mreq_line(mreq_line), .mreq_data(mreq_data),
  .cout_valid(cout_valid), .cout_ready(cout_ready), .cout_kind(cout_kind),
  .cout_dst(cout_dst), .cout_line(cout_line));

// File: tb/sim_dir_dma_ctrl.sv
module sim_dir_dma_ctrl;
  localparam int LBY = 64, LB = 512, LAW = 8, IDW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic creq_valid = 0, creq_ready; logic [7:0] creq_line = 0; logic [1:0] creq_src = 0;
  logic crsp_valid = 0, crsp_ready, crsp_dirty = 0; logic [7:0] crsp_line = 0; logic [1:0] crsp_src = 0;
  logic [LB-1:0] crsp_data = '0;
  logic dreq_valid = 0, dreq_ready, dreq_write = 0; logic [13:0] dreq_addr = 0; logic [6:0] dreq_len = 0;
  logic [LB-1:0] dreq_data = '0;
  logic mreq_valid, mreq_ready = 1, mreq_write; logic [7:0] mreq_line; logic [LB-1:0] mreq_data;
  logic [LBY-1:0] mreq_be;
  logic mrsp_valid = 0, mrsp_ready, mrsp_ack = 0; logic [7:0] mrsp_line = 0; logic [LB-1:0] mrsp_data = '0;
  logic cout_valid, cout_ready = 1; logic [1:0] cout_kind, cout_dst; logic [7:0] cout_line;
  logic [LB-1:0] cout_data;
  logic dout_valid, dout_ready = 1, dout_ack; logic [7:0] dout_line; logic [LB-1:0] dout_data;

  dir_dma_ctrl #(.LINE_BYTES(LBY), .ENTRIES(4), .LAW(LAW), .IDW(IDW)) u0 (.*);

  int n_chk = 0, n_err = 0;
  logic [1:0] cq_k[$], cq_d[$]; logic [7:0] cq_a[$]; logic [LB-1:0] cq_x[$];
  logic mq_w[$]; logic [7:0] mq_a[$]; logic [LB-1:0] mq_x[$]; logic [LBY-1:0] mq_be[$];
  logic dq_k[$]; logic [7:0] dq_a[$]; logic [LB-1:0] dq_x[$];

  always @(negedge clk) if (rst_n) begin
    if (cout_valid && cout_ready) begin
      cq_k.push_back(cout_kind); cq_d.push_back(cout_dst); cq_a.push_back(cout_line); cq_x.push_back(cout_data);
    end
    if (mreq_valid && mreq_ready) begin
      mq_w.push_back(mreq_write); mq_a.push_back(mreq_line); mq_x.push_back(mreq_data); mq_be.push_back(mreq_be);
    end
    if (dout_valid && dout_ready) begin
      dq_k.push_back(dout_ack); dq_a.push_back(dout_line); dq_x.push_back(dout_data);
    end
  end

  task automatic chk(input string tag, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [LB-1:0] rnd();
    logic [LB-1:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [LBY-1:0] exp_mask(input int off, input int len);
    logic [LBY-1:0] m = '0;
    for (int b = off; b < off + len; b++) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [LB-1:0] exp_merge(input logic [LB-1:0] old, input logic [LB-1:0] nw,
                                              input int off, input int len);
    logic [LB-1:0] r = old;
    for (int b = off; b < off + len; b++) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic wait_q(input int which);
    int n = 0;
    while (n < 300 && ((which == 0 && cq_k.size() == 0) || (which == 1 && mq_w.size() == 0) ||
                       (which == 2 && dq_k.size() == 0))) begin
      @(negedge clk); #1; n++;
    end
  endtask

  task automatic get_c(input string tag, input logic [1:0] k, input logic [1:0] d, input logic [7:0] a,
                       input logic [LB-1:0] x);
    wait_q(0);
    if (cq_k.size() == 0) begin chk({tag, " cache out missing"}, 0, 1); return; end
    chk({tag, " cout kind"}, cq_k.pop_front(), k);
    chk({tag, " cout dst"}, cq_d.pop_front(), d);
    chk({tag, " cout line"}, cq_a.pop_front(), a);
    if (k == 2'd0) chk({tag, " cout data"}, cq_x.pop_front(), x); else void'(cq_x.pop_front());
  endtask

  task automatic get_m(input string tag, input logic w, input logic [7:0] a, input logic [LB-1:0] x,
                       input logic [LBY-1:0] be);
    wait_q(1);
    if (mq_w.size() == 0) begin chk({tag, " mem req missing"}, 0, 1); return; end
    chk({tag, " mreq write"}, mq_w.pop_front(), w);
    chk({tag, " mreq line"}, mq_a.pop_front(), a);
    if (w) begin
      chk({tag, " mreq data"}, mq_x.pop_front(), x);
      chk({tag, " mreq be"}, mq_be.pop_front(), be);
    end else begin void'(mq_x.pop_front()); void'(mq_be.pop_front()); end
  endtask

  task automatic get_d(input string tag, input logic k, input logic [7:0] a, input logic [LB-1:0] x);
    wait_q(2);
    if (dq_k.size() == 0) begin chk({tag, " dma out missing"}, 0, 1); return; end
    chk({tag, " dout ack"}, dq_k.pop_front(), k);
    chk({tag, " dout line"}, dq_a.pop_front(), a);
    if (!k) chk({tag, " dout data"}, dq_x.pop_front(), x); else void'(dq_x.pop_front());
  endtask

  task automatic push_creq(input logic [7:0] a, input logic [1:0] s);
    @(negedge clk); creq_line = a; creq_src = s; creq_valid = 1;
    #1; while (!creq_ready) begin @(negedge clk); #1; end
    @(negedge clk); creq_valid = 0;
  endtask

  task automatic push_crsp(input logic dirty, input logic [7:0] a, input logic [1:0] s, input logic [LB-1:0] x);
    @(negedge clk); crsp_dirty = dirty; crsp_line = a; crsp_src = s; crsp_data = x; crsp_valid = 1;
    #1; while (!crsp_ready) begin @(negedge clk); #1; end
    @(negedge clk); crsp_valid = 0;
  endtask

  task automatic push_dreq(input logic w, input logic [7:0] a, input int off, input int len, input logic [LB-1:0] x);
    @(negedge clk); dreq_write = w; dreq_addr = {a, 6'(off)}; dreq_len = 7'(len); dreq_data = x; dreq_valid = 1;
    #1; while (!dreq_ready) begin @(negedge clk); #1; end
    @(negedge clk); dreq_valid = 0;
  endtask

  task automatic push_mrsp(input logic ack, input logic [7:0] a, input logic [LB-1:0] x);
    @(negedge clk); mrsp_ack = ack; mrsp_line = a; mrsp_data = x; mrsp_valid = 1;
    #1; while (!mrsp_ready) begin @(negedge clk); #1; end
    @(negedge clk); mrsp_valid = 0;
  endtask

  task automatic fetch_to_m(input logic [7:0] a, input logic [1:0] s);
    logic [LB-1:0] d = rnd();
    push_creq(a, s);
    get_m("R1 fetch", 0, a, '0, '0);
    push_mrsp(0, a, d);
    get_c("R1 grant", 2'd0, s, a, d);
  endtask

  task automatic clean_rel(input logic [7:0] a, input logic [1:0] s);
    push_crsp(0, a, s, '0);
    get_c("R2 clean", 2'd1, s, a, '0);
  endtask

  task automatic dirty_wb(input logic [7:0] a, input logic [1:0] s);
    logic [LB-1:0] d = rnd();
    push_crsp(1, a, s, d);
    get_m("R3 writeback", 1, a, d, '1);
    push_mrsp(1, a, '0);
    get_c("R3 ack", 2'd1, s, a, '0);
  endtask

  task automatic dma_rd_m(input logic [7:0] a, input logic [1:0] s);
    logic [LB-1:0] d = rnd();
    push_dreq(0, a, 0, 64, '0);
    get_c("R4 inv", 2'd2, s, a, '0);
    push_crsp(1, a, s, d);
    get_d("R4 data", 0, a, d);
    get_m("R4 writeback", 1, a, d, '1);
    push_mrsp(1, a, '0);
    get_c("R4 ack", 2'd1, s, a, '0);
  endtask

  task automatic dma_wr_m(input logic [7:0] a, input logic [1:0] s, input int off, input int len);
    logic [LB-1:0] dd = rnd(), od = rnd();
    push_dreq(1, a, off, len, dd);
    get_c("R5 inv", 2'd2, s, a, '0);
    push_crsp(1, a, s, od);
    get_m("R5 merge", 1, a, exp_merge(od, dd, off, len), '1);
    push_mrsp(1, a, '0);
    get_c("R5 cache ack", 2'd1, s, a, '0);
    get_d("R5 dma ack", 1, a, '0);
  endtask

  task automatic dma_rd_i(input logic [7:0] a);
    logic [LB-1:0] d = rnd();
    push_dreq(0, a, 0, 64, '0);
    get_m("R6 read", 0, a, '0, '0);
    push_mrsp(0, a, d);
    get_d("R6 data", 0, a, d);
  endtask

  task automatic dma_wr_i(input logic [7:0] a, input int off, input int len);
    logic [LB-1:0] dd = rnd();
    push_dreq(1, a, off, len, dd);
    get_m("R6 partial", 1, a, dd, exp_mask(off, len));
    push_mrsp(1, a, '0);
    get_d("R6 ack", 1, a, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [LB-1:0] d;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk("reset mreq_valid", mreq_valid, 0);
    chk("reset cout_valid", cout_valid, 0);
    chk("reset dout_valid", dout_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 30; k++) begin
      logic [7:0] a = 8'($urandom);
      logic [1:0] s = 2'($urandom);
      int off = $urandom % 64;
      int len = 1 + ($urandom % (64 - off));
      case ($urandom % 6)
        0: begin fetch_to_m(a, s); clean_rel(a, s); end
        1: begin fetch_to_m(a, s); dirty_wb(a, s); end
        2: begin fetch_to_m(a, s); dma_rd_m(a, s); end
        3: begin fetch_to_m(a, s); dma_wr_m(a, s, off, len); end
        4: dma_rd_i(a);
        default: dma_wr_i(a, off, len);
      endcase
    end
    fetch_to_m(8'h40, 2'd1); dma_wr_m(8'h40, 2'd1, 0, 64);
    fetch_to_m(8'h41, 2'd2); dma_wr_m(8'h41, 2'd2, 63, 1);
    dma_wr_i(8'h42, 5, 1);

    // R7 held fetch, R9 other channel still moves
    fetch_to_m(8'hA0, 2'd0);
    @(negedge clk); creq_line = 8'hA0; creq_src = 2'd1; creq_valid = 1;
    for (int i = 0; i < 4; i++) begin #1; chk("R7 fetch held", creq_ready, 0); @(negedge clk); end
    dreq_write = 0; dreq_addr = {8'hB0, 6'd0}; dreq_len = 7'd64; dreq_valid = 1;
    #1; chk("R9 dma accepted beside held fetch", dreq_ready, 1);
    @(negedge clk); dreq_valid = 0;
    get_m("R9 read", 0, 8'hB0, '0, '0);
    d = rnd(); push_mrsp(0, 8'hB0, d); get_d("R9 data", 0, 8'hB0, d);
    clean_rel(8'hA0, 2'd0);
    get_m("R7 released fetch", 0, 8'hA0, '0, '0);
    @(negedge clk); creq_valid = 0;
    d = rnd(); push_mrsp(0, 8'hA0, d); get_c("R7 grant", 2'd0, 2'd1, 8'hA0, d);
    clean_rel(8'hA0, 2'd1);

    // R8 DMA held in transient state
    push_creq(8'hC0, 2'd2);
    get_m("R8 fetch", 0, 8'hC0, '0, '0);
    @(negedge clk); dreq_write = 0; dreq_addr = {8'hC0, 6'd0}; dreq_len = 7'd64; dreq_valid = 1;
    for (int i = 0; i < 3; i++) begin #1; chk("R8 dma held", dreq_ready, 0); @(negedge clk); end
    d = rnd(); push_mrsp(0, 8'hC0, d);
    get_c("R8 grant", 2'd0, 2'd2, 8'hC0, d);
    get_c("R8 inv after settle", 2'd2, 2'd2, 8'hC0, '0);
    @(negedge clk); dreq_valid = 0;
    d = rnd(); push_crsp(1, 8'hC0, 2'd2, d);
    get_d("R8 data", 0, 8'hC0, d);
    get_m("R8 writeback", 1, 8'hC0, d, '1);
    push_mrsp(1, 8'hC0, '0); get_c("R8 ack", 2'd1, 2'd2, 8'hC0, '0);

    // R11 table full
    for (int i = 0; i < 4; i++) fetch_to_m(8'h10 + 8'(i), 2'(i));
    @(negedge clk); creq_line = 8'h20; creq_src = 2'd0; creq_valid = 1;
    for (int i = 0; i < 3; i++) begin #1; chk("R11 full table holds", creq_ready, 0); @(negedge clk); end
    clean_rel(8'h10, 2'd0);
    get_m("R11 entry reused", 0, 8'h20, '0, '0);
    @(negedge clk); creq_valid = 0;
    d = rnd(); push_mrsp(0, 8'h20, d); get_c("R11 grant", 2'd0, 2'd0, 8'h20, d);
    for (int i = 1; i < 4; i++) clean_rel(8'h10 + 8'(i), 2'(i));
    clean_rel(8'h20, 2'd0);

    // R12 priority memory response over cache response
    push_creq(8'hD0, 2'd0); get_m("R12 fetch", 0, 8'hD0, '0, '0);
    fetch_to_m(8'hD1, 2'd1);
    d = rnd();
    @(negedge clk);
    mrsp_ack = 0; mrsp_line = 8'hD0; mrsp_data = d; mrsp_valid = 1;
    crsp_dirty = 0; crsp_line = 8'hD1; crsp_src = 2'd1; crsp_valid = 1;
    #1; chk("R12 mem response first", {mrsp_ready, crsp_ready}, 2'b10);
    @(negedge clk); mrsp_valid = 0;
    #1; while (!crsp_ready) begin @(negedge clk); #1; end
    @(negedge clk); crsp_valid = 0;
    get_c("R12 grant", 2'd0, 2'd0, 8'hD0, d);
    get_c("R12 clean", 2'd1, 2'd1, 8'hD1, '0);
    clean_rel(8'hD0, 2'd0);

    // R12 output stable under back-pressure
    mreq_ready = 0;
    push_creq(8'hE0, 2'd3);
    for (int i = 0; i < 3; i++) begin
      chk("R12 mreq held valid", mreq_valid, 1);
      chk("R12 mreq held line", mreq_line, 8'hE0);
      @(negedge clk);
    end
    mreq_ready = 1;
    get_m("R12 released", 0, 8'hE0, '0, '0);
    d = rnd(); push_mrsp(0, 8'hE0, d); get_c("R12 grant", 2'd0, 2'd3, 8'hE0, d);
    dirty_wb(8'hE0, 2'd3);

    repeat (4) @(negedge clk);
    chk("end no stray cache out", cq_k.size(), 0);
    chk("end no stray mem req", mq_w.size(), 0);
    chk("end no stray dma out", dq_k.size(), 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule